// File: doc/BRIEF.md
# DMA Transfer Count Unit with Reload

This block keeps the transfer count for one DMA channel. Software programs a working count through a small register port. A busy transfer then loses one count for each completed transfer unit that the data path reports. When the count runs out, the block raises a one-cycle end-of-transfer flag. The count field is 24 bits wide and sits in a 32-bit register. A programmed zero stands for the largest count, 2^24 units, because the counter wraps through its all-ones value before it reaches the end.

A second register holds a reload count. When reload is enabled at the moment a transfer ends, the reload value is copied into the working counter and the channel stays busy. Software can therefore write the next count while the current transfer is still running. When reload is disabled, the reload register never reaches the working counter. Every transfer unit counts as one, whatever its size code, and that includes a 16-byte unit.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, the remaining count and the reload register both read as zero, and busy and the end flag are low.
- R2: A register write with reg_wr_sel = 0 loads bits 23:0 of reg_wr_data into the working count and sets busy on the next edge. Bits 31:24 of the write data are ignored. A read with reg_rd_sel = 0 returns the working count in bits 23:0, with zeros above.
- R3: A register write with reg_wr_sel = 1 stores bits 23:0 of reg_wr_data in the reload register. A read with reg_rd_sel = 1 returns that value with bits 31:24 always zero.
- R4: While busy, each unit_done strobe lowers the remaining count by exactly one on the next edge, and the count does not change without a strobe. While not busy, a unit_done strobe is ignored.
- R5: The unit_size code (3 bits, any value 0 to 7, where 4 means a 16-byte unit) has no effect on how much a strobe takes off the count.
- R6: A strobe taken at a remaining count of 1 raises xfer_end for exactly the next cycle. If no further end follows, xfer_end is low again in the cycle after that.
- R7: A programmed count of 0 means 2^24 units. A strobe at count 0 gives 0xFFFFFF, leaves busy high and does not raise xfer_end.
- R8: If reload_en is high when a transfer ends, the working count takes the reload register value held before that edge, and busy stays high.
- R9: A reload-register write made during a transfer leaves the working count unchanged. The new value is used only at a later reload.
- R10: If reload_en is low when a transfer ends, the remaining count goes to 0 and busy goes low, whatever the reload register holds.
- R11: When a working-count write and a unit_done strobe arrive in the same cycle, the written value is loaded and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 = working count, 1 = reload register |
| reg_wr_data | input | 32 | Write data; only bits 23:0 are used |
| reg_rd_sel | input | 1 | Read source: 0 = working count, 1 = reload register |
| reg_rd_data | output | 32 | Read data, combinational from the selected register |
| unit_done | input | 1 | One transfer unit has completed |
| reload_en | input | 1 | Reload the working count at the end of a transfer |
| unit_size | input | 3 | Size code of the completed unit |
| remaining | output | 24 | Current working count |
| xfer_end | output | 1 | End-of-transfer pulse |
| busy | output | 1 | A transfer is in progress |

## Verification
The remaining count, busy and xfer_end are all registered, so each one answers a write or strobe on the first clock edge after the cycle in which that input was presented. The bench drives its inputs 1 ns after a rising edge. A behavioural model advances on the same rising edge, and the outputs are compared with it at the falling edge. The directed checks sample just after the edge that follows each stimulus. Read data is combinational from the registers, so it follows reg_rd_sel in the same cycle and shows a write one edge after the write.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;

   // Register selector shared by the write and read ports
   typedef enum logic {
      SEL_WORK   = 1'b0,
      SEL_SHADOW = 1'b1
   } reg_sel_e;

   // Counter actions, in priority order
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_DEC    = 2'd2,
      ACT_FINISH = 2'd3
   } cnt_act_e;

endpackage

// File: rtl/dma_shadow_reg.sv
module dma_shadow_reg #(
   parameter int CNT_W      = 24,
   parameter bit HAS_RELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] shadow
);

   generate
      if (HAS_RELOAD) begin : g_store
         logic [CNT_W-1:0] store_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store_q <= '0;
            else if (wr_en)
               store_q <= wr_val;
         end
         assign shadow = store_q;
      end else begin : g_none
         logic unused_in;
         assign unused_in = wr_en ^ (^wr_val) ^ clk ^ rst_n;
         assign shadow    = '0;
      end
   endgenerate

endmodule

// File: rtl/dma_work_counter.sv
module dma_work_counter
   import dma_cnt_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             unit_tick,
   input  logic             reload_on,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             active,
   output logic             end_pulse
);

   localparam logic [CNT_W-1:0] LAST_UNIT = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             end_q;
   cnt_act_e         act;

   // A write has priority over a strobe. A strobe only counts while busy.
   always_comb begin
      if (load)
         act = ACT_LOAD;
      else if (unit_tick && act_q)
         act = (cnt_q == LAST_UNIT) ? ACT_FINISH : ACT_DEC;
      else
         act = ACT_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
         end_q <= 1'b0;
      end else begin
         end_q <= 1'b0;
         unique case (act)
            ACT_LOAD: begin
               cnt_q <= load_val;
               act_q <= 1'b1;
            end
            ACT_DEC: begin
               cnt_q <= cnt_q - LAST_UNIT;
            end
            ACT_FINISH: begin
               end_q <= 1'b1;
               if (reload_on) begin
                  cnt_q <= reload_val;
               end else begin
                  cnt_q <= '0;
                  act_q <= 1'b0;
               end
            end
            default: begin
               cnt_q <= cnt_q;
            end
         endcase
      end
   end

   assign count     = cnt_q;
   assign active    = act_q;
   assign end_pulse = end_q;

endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
   import dma_cnt_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int REG_W = 32
) (
   input  logic             sel,
   input  logic [CNT_W-1:0] work_val,
   input  logic [CNT_W-1:0] shadow_val,
   output logic [REG_W-1:0] rd_data
);

   localparam int PAD_W = REG_W - CNT_W;

   logic [CNT_W-1:0] picked;
   assign picked = (reg_sel_e'(sel) == SEL_SHADOW) ? shadow_val : work_val;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, picked};
      end else begin : g_exact
         assign rd_data = picked;
      end
   endgenerate

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
   import dma_cnt_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int REG_W      = 32,
   parameter int SIZE_W     = 3,
   parameter bit HAS_RELOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_wr_sel,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic              reg_rd_sel,
   output logic [REG_W-1:0]  reg_rd_data,
   input  logic              unit_done,
   input  logic              reload_en,
   input  logic [SIZE_W-1:0] unit_size,
   output logic [CNT_W-1:0]  remaining,
   output logic              xfer_end,
   output logic              busy
);

   localparam int N_SIZES = 1 << SIZE_W;

   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_width
         $error("dma_xfer_counter: CNT_W must be between 2 and REG_W");
      end
      if (SIZE_W < 1 || SIZE_W > 6) begin : g_bad_size
         $error("dma_xfer_counter: SIZE_W out of range");
      end
   endgenerate

   // Every unit size code is worth one count.
   logic [N_SIZES-1:0] unit_weight;
   generate
      for (genvar s = 0; s < N_SIZES; s++) begin : g_weight
         assign unit_weight[s] = 1'b1;
      end
   endgenerate

   logic             wr_work;
   logic             wr_shadow;
   logic             tick;
   logic [CNT_W-1:0] wr_low;
   logic [CNT_W-1:0] shadow_q;

   assign wr_work   = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_WORK);
   assign wr_shadow = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_SHADOW);
   assign wr_low    = reg_wr_data[CNT_W-1:0];
   assign tick      = unit_done && unit_weight[unit_size];

   dma_shadow_reg #(
      .CNT_W      (CNT_W),
      .HAS_RELOAD (HAS_RELOAD)
   ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_shadow),
      .wr_val (wr_low),
      .shadow (shadow_q)
   );

   dma_work_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_work),
      .load_val   (wr_low),
      .unit_tick  (tick),
      .reload_on  (reload_en && HAS_RELOAD),
      .reload_val (shadow_q),
      .count      (remaining),
      .active     (busy),
      .end_pulse  (xfer_end)
   );

   dma_rd_mux #(
      .CNT_W (CNT_W),
      .REG_W (REG_W)
   ) u_rd (
      .sel        (reg_rd_sel),
      .work_val   (remaining),
      .shadow_val (shadow_q),
      .rd_data    (reg_rd_data)
   );

endmodule

// File: rtl/dma_xfer_counter_chk.sv
module dma_xfer_counter_chk #(
   parameter int CNT_W  = 24,
   parameter int REG_W  = 32,
   parameter int SIZE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic              reg_wr_sel,
   input logic [REG_W-1:0]  reg_wr_data,
   input logic [REG_W-1:0]  reg_rd_data,
   input logic              unit_done,
   input logic              reload_en,
   input logic [SIZE_W-1:0] unit_size,
   input logic [CNT_W-1:0]  remaining,
   input logic              xfer_end,
   input logic              busy,
   input logic [CNT_W-1:0]  shadow_q
);

   localparam logic [REG_W-1:0]  LOW_MASK = REG_W'({CNT_W{1'b1}});
   localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

   logic [REG_W-1:0] wr_masked;
   assign wr_masked = reg_wr_data & LOW_MASK;

   logic step_mid;
   logic step_last;
   assign step_mid  = busy && unit_done && !(reg_wr_en && !reg_wr_sel) && remaining != ONE;
   assign step_last = busy && unit_done && !(reg_wr_en && !reg_wr_sel) && remaining == ONE;

   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      step_mid |=> remaining == $past(remaining) - ONE); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !reg_wr_en) |=> $stable(remaining) && !busy); // R4

   AST_SIZE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_mid && unit_size == '1) |=> remaining == $past(remaining) - ONE); // R5

   AST_END_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      step_last |=> xfer_end); // R6

   AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_last |=> !xfer_end); // R6

   AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && unit_done && !reg_wr_en && remaining == '0) |=> remaining == '1 && busy); // R7

   AST_RELOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_last && reload_en) |=> busy && remaining == $past(shadow_q)); // R8

   AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_last && !reload_en) |=> !busy && remaining == '0); // R10

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !reg_wr_sel) |=> busy && remaining == $past(wr_masked[CNT_W-1:0])); // R11

   AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel) |=> shadow_q == $past(wr_masked[CNT_W-1:0])); // R3

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data & ~LOW_MASK) == '0); // R3

endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(
   .CNT_W  (CNT_W),
   .REG_W  (REG_W),
   .SIZE_W (SIZE_W)
) u_chk (.*);

// File: tb/dma_xfer_counter_test.sv
`timescale 1ns/1ps
module dma_xfer_counter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_wr_sel = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic        reg_rd_sel = 1'b0;
   logic [31:0] reg_rd_data;
   logic        unit_done = 1'b0;
   logic        reload_en = 1'b0;
   logic [2:0]  unit_size = '0;
   logic [23:0] remaining;
   logic        xfer_end;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_xfer_counter uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_sel  (reg_wr_sel),
      .reg_wr_data (reg_wr_data),
      .reg_rd_sel  (reg_rd_sel),
      .reg_rd_data (reg_rd_data),
      .unit_done   (unit_done),
      .reload_en   (reload_en),
      .unit_size   (unit_size),
      .remaining   (remaining),
      .xfer_end    (xfer_end),
      .busy        (busy)
   );

   // Behavioural reference model
   longint m_cnt = 0;
   longint m_shadow = 0;
   bit     m_busy = 0;
   bit     m_end = 0;
   localparam longint FULL = 64'h1000000;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_shadow = 0; m_busy = 0; m_end = 0;
      end else begin
         longint old_shadow;
         old_shadow = m_shadow;
         m_end = 0;
         if (reg_wr_en && !reg_wr_sel) begin
            m_cnt  = longint'(reg_wr_data) % FULL;
            m_busy = 1;
         end else if (m_busy && unit_done) begin
            if (m_cnt == 1) begin
               m_end = 1;
               if (reload_en) m_cnt = old_shadow;
               else begin m_cnt = 0; m_busy = 0; end
            end else begin
               m_cnt = (m_cnt + FULL - 1) % FULL;
            end
         end
         if (reg_wr_en && reg_wr_sel)
            m_shadow = longint'(reg_wr_data) % FULL;
      end
   end

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Compare with the model on every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R4 remaining vs model", longint'(remaining), m_cnt);
         check("R6 xfer_end vs model", longint'(xfer_end), longint'(m_end));
         check("R10 busy vs model", longint'(busy), longint'(m_busy));
         check("R3 read data vs model", longint'(reg_rd_data),
               reg_rd_sel ? m_shadow : m_cnt);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(bit sel, logic [31:0] d);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      tick();
      reg_wr_en = 1'b0;
   endtask

   task automatic strobe(logic [2:0] sz);
      unit_done = 1'b1; unit_size = sz;
      tick();
      unit_done = 1'b0;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #400000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 remaining", remaining, 0);
      check("R1 busy", busy, 0);
      check("R1 xfer_end", xfer_end, 0);
      reg_rd_sel = 1'b1; #0.1;
      check("R1 reload reg", reg_rd_data, 0);
      reg_rd_sel = 1'b0;

      // R2 load working count, upper bits dropped
      wr(1'b0, 32'hAB00_0005);
      check("R2 remaining", remaining, 5);
      check("R2 busy", busy, 1);
      check("R2 read", reg_rd_data, 32'h0000_0005);

      // R4 / R5 decrement by one for different unit sizes
      strobe(3'd0);
      check("R4 dec", remaining, 4);
      strobe(3'd4);
      check("R5 16-byte unit", remaining, 3);
      tick();
      check("R4 hold without strobe", remaining, 3);

      // R3 / R9 reload register written mid transfer
      wr(1'b1, 32'hFF00_0010);
      check("R9 count kept", remaining, 3);
      reg_rd_sel = 1'b1; #0.1;
      check("R3 read reload", reg_rd_data, 32'h0000_0010);
      reg_rd_sel = 1'b0;

      // R6 / R10 end without reload
      reload_en = 1'b0;
      strobe(3'd7);
      strobe(3'd2);
      check("R6 at one", remaining, 1);
      strobe(3'd1);
      check("R6 end flag", xfer_end, 1);
      check("R10 remaining", remaining, 0);
      check("R10 busy", busy, 0);
      tick();
      check("R6 one cycle", xfer_end, 0);

      // R4 strobe while idle ignored
      strobe(3'd0);
      check("R4 idle ignored", remaining, 0);
      check("R4 idle busy", busy, 0);

      // R8 end with reload
      wr(1'b0, 32'h2);
      reload_en = 1'b1;
      strobe(3'd0);
      strobe(3'd0);
      check("R8 end flag", xfer_end, 1);
      check("R8 reloaded", remaining, 32'h10);
      check("R8 busy", busy, 1);

      // R7 zero means maximum
      wr(1'b0, 32'h0);
      strobe(3'd5);
      check("R7 wrap", remaining, 32'hFF_FFFF);
      check("R7 no end", xfer_end, 0);
      check("R7 busy", busy, 1);

      // R11 write and strobe together
      reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'h7; unit_done = 1'b1;
      tick();
      reg_wr_en = 1'b0; unit_done = 1'b0;
      check("R11 write wins", remaining, 7);

      // R9 reload uses the value held before a same-cycle reload write
      wr(1'b0, 32'h1);
      reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = 32'h20; unit_done = 1'b1;
      tick();
      reg_wr_en = 1'b0; unit_done = 1'b0;
      check("R9 old reload value", remaining, 32'h10);
      reg_rd_sel = 1'b1; #0.1;
      check("R9 new reload stored", reg_rd_data, 32'h20);

      // Random phase, compared against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         reg_wr_en   = (r < 8);
         reg_wr_sel  = $urandom_range(0, 1);
         reg_wr_data = {8'($urandom), 16'h0, 8'($urandom_range(0, 6))};
         unit_done   = ($urandom_range(0, 99) < 60);
         reload_en   = ($urandom_range(0, 1) == 1);
         unit_size   = 3'($urandom);
         reg_rd_sel  = $urandom_range(0, 1);
         tick();
      end
      reg_wr_en = 1'b0; unit_done = 1'b0;
      tick();
      summary();
   end

endmodule